// File: doc/BRIEF.md
# Linked-Descriptor DMA Walker

This block moves a data stream between system memory and a data FIFO by following a chain of descriptors that software has placed in memory. Each descriptor is four 32-bit words at consecutive word addresses: a configuration word, a buffer size, a buffer address and the address of the next descriptor. The engine reads all four words, checks that the descriptor has been handed to hardware, and moves the buffer one word at a time. It then hands the descriptor back by clearing its ownership flag in memory and continues at the next pointer. A direction input selects one of two transfer types. A card write takes words from memory and pushes them into the FIFO. A card read pops words from the FIFO and stores them to memory.

Software uses three registers. It writes the address of the first descriptor, starts the walk through the control register, and reads the sticky completion and error flags in the status register. The status register also shows the walk state as a live 4-bit code. When the engine finishes a descriptor flagged as the last one, it raises a one-cycle completion pulse to the interrupt logic. The memory port carries one request at a time. The request is held until its response arrives, and a response can report a bus error.

Top module: `chain_dma`

## Requirements
- R1: After reset the status register reads zero, which includes state code 0 (idle), and no memory request, FIFO push, FIFO pop or completion pulse is issued.
- R2: A write to the control register (address 0) with bit 7 set and bit 0 clear starts a walk. From idle the walk starts at the list base register (address 1). From suspend it fetches the same descriptor again. A control write with bit 7 clear starts nothing.
- R3: A descriptor at address A is read as four words from A, A+4, A+8 and A+12, in the order configuration, size, buffer address, next address. Once a descriptor is finished, the following one is fetched from its next address. A memory request stays asserted until its response arrives.
- R4: A fetched descriptor whose configuration bit 31 (ownership, 1 = engine owns it) is clear sets status bit 4 and moves to state code 1 (suspend). No data moves and that descriptor is left unmodified in memory.
- R5: The byte count is size-word bits [SIZE_BITS-1:0] with the two low bits zero. Higher bits are ignored. A count of zero means 2^SIZE_BITS bytes, and count/4 words are moved.
- R6: With dir_rx low, buffer words are read at ascending addresses and pushed to the FIFO, and only in cycles where tx_full is low. With dir_rx high, words are popped only when rx_empty is low and are written at ascending addresses.
- R7: After a buffer is finished, the configuration word is written back to the descriptor's first word with bit 31 cleared and every other bit unchanged.
- R8: When the written-back descriptor has configuration bit 2 (last) set, the engine sets status bit 0 (dir_rx low) or status bit 1 (dir_rx high), pulses xfer_done for one cycle and returns to idle.
- R9: A memory response with mem_err set sets status bit 2 and returns the engine to idle. No further requests follow.
- R10: Writing control bit 0 resets the engine. Within two cycles the state code is idle, the status flags and control bits are clear, and bit 0 reads back as zero.
- R11: Writing 1 to status bits 0, 1, 2 or 4 clears that flag. Status bits 16:13 report the state: 0 idle, 1 suspend, 2 descriptor fetch, 3 descriptor check, 4 memory-read wait, 5 memory-write wait, 6 FIFO pop, 7 FIFO push, 8 descriptor close.
- R12: Control bits 1 (fixed burst) and 7 (enable) read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 list base, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| dir_rx | input | 1 | 1 = FIFO to memory, 0 = memory to FIFO; sampled at start |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response for the current request |
| mem_rdata | input | 32 | Read data with response |
| mem_err | input | 1 | Response reports a bus error |
| tx_push | output | 1 | Push a word into the outgoing FIFO |
| tx_data | output | 32 | Word pushed |
| tx_full | input | 1 | Outgoing FIFO cannot accept |
| rx_pop | output | 1 | Pop a word from the incoming FIFO |
| rx_data | input | 32 | Head word of incoming FIFO |
| rx_empty | input | 1 | Incoming FIFO has no word |
| xfer_done | output | 1 | One-cycle pulse on completion of a last descriptor |

## Verification
Chains are placed at descending addresses, so following the next pointer gives a different order from plain sequential fetch. The chains run in both directions with varying lengths. FIFO flow control is either free, randomly throttled or held stalled, and a held stall shows the push and pop state codes while no word moves. Directed cases cover a descriptor that is not owned in the middle of a chain followed by a resume, a zero size field with garbage above the count field, an error response in the middle of a buffer, and a soft reset during a long transfer. Each of these separates a correct stop from a wrong count or a run-on.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    typedef enum logic [3:0] {
        WS_IDLE  = 4'd0,
        WS_SUSP  = 4'd1,
        WS_FETCH = 4'd2,
        WS_CHECK = 4'd3,
        WS_MRD   = 4'd4,
        WS_MWR   = 4'd5,
        WS_POP   = 4'd6,
        WS_PUSH  = 4'd7,
        WS_CLOSE = 4'd8
    } walk_state_e;

    localparam int CFG_LAST = 2;
    localparam int CFG_OWN  = 31;

    localparam int CTL_SRST = 0;
    localparam int CTL_FIXB = 1;
    localparam int CTL_EN   = 7;

    localparam int STS_TXDONE = 0;
    localparam int STS_RXDONE = 1;
    localparam int STS_FATAL  = 2;
    localparam int STS_UNAV   = 4;
    localparam int STS_FSM_LO = 13;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
endpackage

// File: rtl/cdma_len_decode.sv
module cdma_len_decode #(
    parameter int SIZE_BITS = 13
) (
    input  logic [SIZE_BITS-1:0] size_field,
    output logic [SIZE_BITS-2:0] words
);
    localparam int CNT_W = SIZE_BITS - 1;

    // zero encodes the full 2^SIZE_BITS byte span
    always_comb begin
        if (size_field == '0) begin
            words = CNT_W'(1) << (SIZE_BITS - 2);
        end else begin
            words = CNT_W'(size_field >> 2);
        end
    end
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [3:0]  fsm_state,
    input  logic        set_tx,
    input  logic        set_rx,
    input  logic        set_fatal,
    input  logic        set_unavail,
    output logic [31:0] list_base,
    output logic        soft_rst,
    output logic        kick
);
    typedef struct packed {
        logic        srst;
        logic        fixb;
        logic        en;
        logic [31:0] base;
        logic        txd;
        logic        rxd;
        logic        fatal;
        logic        unav;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        if (q.srst) begin
            d.fixb  = 1'b0;
            d.en    = 1'b0;
            d.txd   = 1'b0;
            d.rxd   = 1'b0;
            d.fatal = 1'b0;
            d.unav  = 1'b0;
        end
        if (wr_en) begin
            case (addr)
                RA_CTRL: begin
                    d.srst = wdata[CTL_SRST];
                    d.fixb = wdata[CTL_FIXB];
                    d.en   = wdata[CTL_EN];
                end
                RA_BASE: d.base = {wdata[31:2], 2'b00};
                RA_STAT: begin
                    if (wdata[STS_TXDONE]) d.txd   = 1'b0;
                    if (wdata[STS_RXDONE]) d.rxd   = 1'b0;
                    if (wdata[STS_FATAL])  d.fatal = 1'b0;
                    if (wdata[STS_UNAV])   d.unav  = 1'b0;
                end
                default: ;
            endcase
        end
        if (set_tx)      d.txd   = 1'b1;
        if (set_rx)      d.rxd   = 1'b1;
        if (set_fatal)   d.fatal = 1'b1;
        if (set_unavail) d.unav  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL: begin
                rdata[CTL_SRST] = q.srst;
                rdata[CTL_FIXB] = q.fixb;
                rdata[CTL_EN]   = q.en;
            end
            RA_BASE: rdata = q.base;
            RA_STAT: begin
                rdata[STS_TXDONE] = q.txd;
                rdata[STS_RXDONE] = q.rxd;
                rdata[STS_FATAL]  = q.fatal;
                rdata[STS_UNAV]   = q.unav;
                rdata[STS_FSM_LO+3:STS_FSM_LO] = fsm_state;
            end
            default: ;
        endcase
    end

    assign list_base = q.base;
    assign soft_rst  = q.srst;
    assign kick      = wr_en && (addr == RA_CTRL) && wdata[CTL_EN]
                       && !wdata[CTL_SRST] && !q.srst;
endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import cdma_pkg::*;
#(
    parameter int SIZE_BITS = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dir_rx,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        tx_push,
    output logic [31:0] tx_data,
    input  logic        tx_full,
    output logic        rx_pop,
    input  logic [31:0] rx_data,
    input  logic        rx_empty,
    output logic        xfer_done
);
    localparam int CNT_W = SIZE_BITS - 1;

    typedef struct packed {
        walk_state_e          st;
        logic [1:0]           widx;
        logic                 rx;
        logic                 done;
        logic [31:0]          daddr;
        logic [31:0]          cfg;
        logic [SIZE_BITS-1:0] size;
        logic [31:0]          bufa;
        logic [31:0]          nxt;
        logic [31:0]          word;
        logic [CNT_W-1:0]     left;
    } walk_t;

    walk_t q, d;

    logic [31:0]      list_base;
    logic             soft_rst;
    logic             kick;
    logic [3:0]       fsm_state;
    logic             set_tx, set_rx, set_fatal, set_unavail;
    logic [CNT_W-1:0] dec_words;
    logic             rsp_ok, rsp_bad;

    cdma_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .fsm_state   (fsm_state),
        .set_tx      (set_tx),
        .set_rx      (set_rx),
        .set_fatal   (set_fatal),
        .set_unavail (set_unavail),
        .list_base   (list_base),
        .soft_rst    (soft_rst),
        .kick        (kick)
    );

    cdma_len_decode #(.SIZE_BITS(SIZE_BITS)) u_len (
        .size_field (q.size),
        .words      (dec_words)
    );

    assign fsm_state = q.st;
    assign rsp_ok    = mem_rvalid && !mem_err;
    assign rsp_bad   = mem_rvalid && mem_err;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        set_tx      = 1'b0;
        set_rx      = 1'b0;
        set_fatal   = 1'b0;
        set_unavail = 1'b0;
        case (q.st)
            WS_IDLE, WS_SUSP: begin
                if (kick) begin
                    if (q.st == WS_IDLE) d.daddr = list_base;
                    d.widx = 2'd0;
                    d.rx   = dir_rx;
                    d.st   = WS_FETCH;
                end
            end
            WS_FETCH: begin
                if (rsp_ok) begin
                    case (q.widx)
                        2'd0: d.cfg  = mem_rdata;
                        2'd1: d.size = {mem_rdata[SIZE_BITS-1:2], 2'b00};
                        2'd2: d.bufa = {mem_rdata[31:2], 2'b00};
                        default: d.nxt = {mem_rdata[31:2], 2'b00};
                    endcase
                    d.widx = q.widx + 2'd1;
                    if (q.widx == 2'd3) d.st = WS_CHECK;
                end
            end
            WS_CHECK: begin
                if (!q.cfg[CFG_OWN]) begin
                    set_unavail = 1'b1;
                    d.st        = WS_SUSP;
                end else begin
                    d.left = dec_words;
                    d.st   = q.rx ? WS_POP : WS_MRD;
                end
            end
            WS_MRD: begin
                if (rsp_ok) begin
                    d.word = mem_rdata;
                    d.st   = WS_PUSH;
                end
            end
            WS_PUSH: begin
                if (!tx_full) begin
                    d.bufa = q.bufa + 32'd4;
                    d.left = q.left - CNT_W'(1);
                    d.st   = (q.left == CNT_W'(1)) ? WS_CLOSE : WS_MRD;
                end
            end
            WS_POP: begin
                if (!rx_empty) begin
                    d.word = rx_data;
                    d.st   = WS_MWR;
                end
            end
            WS_MWR: begin
                if (rsp_ok) begin
                    d.bufa = q.bufa + 32'd4;
                    d.left = q.left - CNT_W'(1);
                    d.st   = (q.left == CNT_W'(1)) ? WS_CLOSE : WS_POP;
                end
            end
            WS_CLOSE: begin
                if (rsp_ok) begin
                    if (q.cfg[CFG_LAST]) begin
                        d.st   = WS_IDLE;
                        d.done = 1'b1;
                        set_rx = q.rx;
                        set_tx = !q.rx;
                    end else begin
                        d.daddr = q.nxt;
                        d.widx  = 2'd0;
                        d.st    = WS_FETCH;
                    end
                end
            end
            default: d.st = WS_IDLE;
        endcase
        if (rsp_bad && mem_req) begin
            set_fatal = 1'b1;
            d.st      = WS_IDLE;
        end
        if (soft_rst) begin
            d           = '0;
            set_tx      = 1'b0;
            set_rx      = 1'b0;
            set_fatal   = 1'b0;
            set_unavail = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            WS_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.daddr + 32'({q.widx, 2'b00});
            end
            WS_MRD: begin
                mem_req  = 1'b1;
                mem_addr = q.bufa;
            end
            WS_MWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.bufa;
                mem_wdata = q.word;
            end
            WS_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.daddr;
                mem_wdata = q.cfg & ~(32'd1 << CFG_OWN);
            end
            default: ;
        endcase
    end

    assign tx_push   = (q.st == WS_PUSH) && !tx_full;
    assign tx_data   = q.word;
    assign rx_pop    = (q.st == WS_POP) && !rx_empty;
    assign xfer_done = q.done;
endmodule

// File: rtl/cdma_checker.sv
module cdma_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] fsm_state,
    input logic       soft_rst,
    input logic       set_unavail,
    input logic       set_fatal,
    input logic       xfer_done,
    input logic       mem_req,
    input logic       mem_rvalid,
    input logic       tx_push,
    input logic       rx_pop
);
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state <= 4'd8); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 4'd0) |-> (!mem_req && !tx_push && !rx_pop)); // R1

    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (fsm_state == 4'd0)); // R10

    AST_UNAV_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        set_unavail |=> (fsm_state == 4'd1)); // R4

    AST_FATAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_fatal |=> (fsm_state == 4'd0)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (fsm_state == 4'd0)); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && !soft_rst) |=> mem_req); // R3
endmodule

bind chain_dma cdma_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsm_state   (fsm_state),
    .soft_rst    (soft_rst),
    .set_unavail (set_unavail),
    .set_fatal   (set_fatal),
    .xfer_done   (xfer_done),
    .mem_req     (mem_req),
    .mem_rvalid  (mem_rvalid),
    .tx_push     (tx_push),
    .rx_pop      (rx_pop)
);

// File: tb/sim_chain_dma.sv
module sim_chain_dma;
    localparam int CLK_PERIOD = 10;
    localparam int SB         = 13;
    localparam int MEMW       = 4096;

    logic        clk, rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        dir_rx;
    logic        mem_req, mem_we, mem_rvalid, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_push, tx_full, rx_pop, rx_empty, xfer_done;
    logic [31:0] tx_data, rx_data;

    chain_dma #(.SIZE_BITS(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_rx(dir_rx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .xfer_done(xfer_done)
    );

    logic [31:0] mem  [0:MEMW-1];
    logic [31:0] txg  [0:MEMW-1];
    logic [31:0] rxs  [0:MEMW-1];
    logic [31:0] expw [0:MEMW-1];
    logic [31:0] ea   [0:MEMW-1];
    logic [31:0] da   [0:7];
    logic [31:0] ecfg [0:7];
    int          dw   [0:7];
    int tx_cnt, rx_idx, exp_n, tx_base, rx_base, nd_g;
    int throttle, req_seen, done_cnt, mem_lat;
    int nchk, nfail;
    bit rx_pend, err_on;
    logic [31:0] err_addr;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory, FIFO and event model, all driven between clock edges
    initial begin
        mem_rvalid = 0; mem_err = 0; mem_rdata = '0; mem_lat = 0;
        tx_full = 0; rx_empty = 1; rx_data = '0; rx_pend = 0;
        forever begin
            @(negedge clk);
            if (rx_pend) rx_idx++;
            if (mem_rvalid) begin
                mem_rvalid = 0;
                mem_err    = 0;
            end else if (mem_req) begin
                if (mem_lat == 0) begin
                    if (err_on && mem_addr == err_addr) mem_err = 1;
                    else if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
                    else mem_rdata = mem[mem_addr[13:2]];
                    mem_rvalid = 1;
                    mem_lat = int'($urandom % 3);
                end else begin
                    mem_lat--;
                end
            end
            tx_full  = (throttle == 2) ? 1'b1 : (throttle == 1) ? (($urandom % 3) == 0) : 1'b0;
            rx_empty = (throttle == 2) ? 1'b1 : (throttle == 1) ? (($urandom % 3) == 0) : 1'b0;
            rx_data  = rxs[rx_idx % MEMW];
            #1;
            if (tx_push && tx_cnt < MEMW) begin
                txg[tx_cnt] = tx_data;
                tx_cnt++;
            end
            rx_pend = rx_pop;
            if (mem_req) req_seen++;
            if (xfer_done) done_cnt++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 60000; i++) begin
            rd(2'd2, s);
            if (s[16:13] == 4'd0 || s[16:13] == 4'd1) break;
        end
    endtask

    // bench model of a chain: descriptors at descending addresses
    task automatic build(input bit rx, input int nd, input int unown, input bit zero);
        exp_n = 0; nd_g = nd;
        tx_base = tx_cnt; rx_base = rx_idx;
        for (int k = 0; k < nd; k++) begin
            logic [31:0] bufa, cfg, szw;
            da[k] = 32'h400 - 32'(32 * k);
            dw[k] = zero ? 2048 : 1 + int'($urandom % 16);
            bufa  = zero ? 32'h2000 : 32'h1000 + 32'(k * 256);
            cfg   = 32'h10 | ({31'd0, $urandom % 2} << 1) | ({31'd0, $urandom % 2} << 10)
                    | ({31'd0, $urandom % 2} << 30);
            if (k != unown) cfg[31] = 1'b1;
            if (k == 0)      cfg[3] = 1'b1;
            if (k == nd - 1) cfg[2] = 1'b1;
            szw = ($urandom & ~32'((1 << SB) - 1)) | (zero ? 32'd0 : 32'(dw[k] * 4));
            ecfg[k] = cfg;
            mem[da[k][13:2]]       = cfg;
            mem[da[k][13:2] + 1]   = szw;
            mem[da[k][13:2] + 2]   = bufa | 32'(rx ? 0 : 0);
            mem[da[k][13:2] + 3]   = (k == nd - 1) ? 32'h0 : da[k] - 32'd32;
            for (int i = 0; i < dw[k]; i++) begin
                logic [31:0] v;
                v = $urandom;
                ea[exp_n] = bufa + 32'(4 * i);
                expw[exp_n] = v;
                if (rx) begin
                    mem[ea[exp_n][13:2]] = 32'h0;
                    rxs[(rx_idx + exp_n) % MEMW] = v;
                end else begin
                    mem[ea[exp_n][13:2]] = v;
                end
                exp_n++;
            end
        end
        dir_rx = rx;
    endtask

    task automatic kickoff();
        wr(2'd1, 32'h400);
        wr(2'd0, 32'h80 | ({31'd0, $urandom % 2} << 1));
    endtask

    task automatic check_data(input bit rx, input int nwords, input int ndesc);
        for (int k = 0; k < ndesc; k++)
            chk("R7 descriptor written back with owner cleared", mem[da[k][13:2]], ecfg[k] & 32'h7fff_ffff);
        if (rx) begin
            chk("R6 words popped", 32'(rx_idx - rx_base), 32'(nwords));
            for (int i = 0; i < nwords; i++)
                chk("R6 word stored to memory", mem[ea[i][13:2]], expw[i]);
        end else begin
            chk("R5 words pushed", 32'(tx_cnt - tx_base), 32'(nwords));
            for (int i = 0; i < nwords; i++)
                chk("R3 word pushed in chain order", txg[tx_base + i], expw[i]);
        end
    endtask

    task automatic full_chain(input bit rx, input int nd, input int thr);
        logic [31:0] s;
        int d0;
        build(rx, nd, -1, 0);
        d0 = done_cnt;
        throttle = thr;
        kickoff();
        wait_stop();
        check_data(rx, exp_n, nd);
        rd(2'd2, s);
        chk("R8 completion flag and idle", s, rx ? 32'h2 : 32'h1);
        chk("R8 one completion pulse", 32'(done_cnt - d0), 32'd1);
        wr(2'd2, 32'h3);
        rd(2'd2, s);
        chk("R11 write one clears completion", s, 32'h0);
    endtask

    initial begin
        logic [31:0] s;
        int snap, d0;
        void'($urandom(32'h5eed_0042));
        nchk = 0; nfail = 0; tx_cnt = 0; rx_idx = 0; req_seen = 0; done_cnt = 0;
        throttle = 0; err_on = 0; err_addr = '0;
        reg_wr = 0; reg_addr = '0; reg_wdata = '0; dir_rx = 0;
        for (int i = 0; i < MEMW; i++) begin mem[i] = '0; rxs[i] = '0; end
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(2'd2, s);
        chk("R1 status after reset", s, 32'h0);
        rd(2'd0, s);
        chk("R12 control after reset", s, 32'h0);
        repeat (4) @(negedge clk);
        chk("R1 no request after reset", 32'(req_seen), 32'd0);
        chk("R1 no completion after reset", 32'(done_cnt), 32'd0);

        // R2 control write without enable starts nothing; R12 readback
        build(0, 1, -1, 0);
        wr(2'd0, 32'h2);
        repeat (10) @(negedge clk);
        chk("R2 no start without enable", 32'(req_seen), 32'd0);
        rd(2'd0, s);
        chk("R12 fixed burst readback", s, 32'h2);

        // R6 stalled FIFO holds push state, no word moves
        build(0, 2, -1, 0);
        throttle = 2;
        kickoff();
        repeat (30) @(negedge clk);
        rd(2'd2, s);
        chk("R11 state code push while stalled", 32'(s[16:13]), 32'd7);
        chk("R6 no push while full", 32'(tx_cnt - tx_base), 32'd0);
        rd(2'd0, s);
        chk("R12 enable readback", 32'(s[7]), 32'd1);
        throttle = 1;
        wait_stop();
        check_data(0, exp_n, 2);
        rd(2'd2, s);
        chk("R8 transmit completion", s, 32'h1);
        wr(2'd2, 32'h1);

        build(1, 2, -1, 0);
        throttle = 2;
        kickoff();
        repeat (30) @(negedge clk);
        rd(2'd2, s);
        chk("R11 state code pop while stalled", 32'(s[16:13]), 32'd6);
        chk("R6 no pop while empty", 32'(rx_idx - rx_base), 32'd0);
        throttle = 0;
        wait_stop();
        check_data(1, exp_n, 2);
        rd(2'd2, s);
        chk("R8 receive completion", s, 32'h2);
        wr(2'd2, 32'h2);

        // random chains in both directions
        for (int it = 0; it < 8; it++)
            full_chain(bit'($urandom % 2), 1 + int'($urandom % 4), int'($urandom % 2));

        // R4 not-owned descriptor mid chain, then resume
        build(0, 3, 1, 0);
        throttle = 1;
        d0 = done_cnt;
        kickoff();
        wait_stop();
        rd(2'd2, s);
        chk("R4 suspend with unavailable flag", s, 32'h0000_2010);
        chk("R4 not-owned descriptor untouched", mem[da[1][13:2]], ecfg[1]);
        chk("R7 first descriptor handed back", mem[da[0][13:2]], ecfg[0] & 32'h7fff_ffff);
        chk("R4 only first buffer moved", 32'(tx_cnt - tx_base), 32'(dw[0]));
        chk("R4 no completion pulse", 32'(done_cnt - d0), 32'd0);
        ecfg[1][31] = 1'b1;
        mem[da[1][13:2]] = ecfg[1];
        wr(2'd2, 32'h10);
        rd(2'd2, s);
        chk("R11 unavailable flag cleared", s, 32'h0000_2000);
        wr(2'd0, 32'h80);
        wait_stop();
        check_data(0, exp_n, 3);
        rd(2'd2, s);
        chk("R2 resume completes chain", s, 32'h1);
        wr(2'd2, 32'h1);

        // R5 zero size means full span
        build(0, 1, -1, 1);
        throttle = 0;
        kickoff();
        wait_stop();
        check_data(0, exp_n, 1);
        chk("R5 zero size moves full span", 32'(tx_cnt - tx_base), 32'd2048);
        wr(2'd2, 32'h1);

        // R9 error response mid buffer
        build(0, 1, -1, 0);
        if (dw[0] < 3) begin
            dw[0] = 3;
            mem[da[0][13:2] + 1] = 32'd12;
        end
        err_on = 1; err_addr = 32'h1008;
        d0 = done_cnt;
        kickoff();
        wait_stop();
        rd(2'd2, s);
        chk("R9 fatal flag and idle", s, 32'h4);
        chk("R9 words before error", 32'(tx_cnt - tx_base), 32'd2);
        chk("R9 no completion on error", 32'(done_cnt - d0), 32'd0);
        snap = req_seen;
        repeat (10) @(negedge clk);
        chk("R9 no request after error", 32'(req_seen - snap), 32'd0);
        err_on = 0;
        wr(2'd2, 32'h4);

        // R10 soft reset during long transfer
        build(0, 1, -1, 1);
        kickoff();
        repeat (40) @(negedge clk);
        wr(2'd0, 32'h1);
        repeat (2) @(negedge clk);
        rd(2'd2, s);
        chk("R10 status and state clear", s, 32'h0);
        rd(2'd0, s);
        chk("R10 control clear and self-cleared", s, 32'h0);
        snap = req_seen;
        repeat (10) @(negedge clk);
        chk("R10 no request after soft reset", 32'(req_seen - snap), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule